// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block steps an on-chip debug session through a short chain of states in response to match pulses from four comparator channels. A session starts when the arm strobe is pulsed. The sequencer then sits in State1. A match in State1 or State2 moves it one state forward. In State3, a 4-bit route code selects which channels send the sequencer to State1, to State2 or to the Final state. When two or more channels match in the same cycle, the conflict is settled by a fixed priority.

Each channel also has a sticky match flag. A flag records that its channel matched at least once while the session was armed. The flags survive the end of the session so that software can inspect them afterwards, and only the next arm strobe clears them. Software reads the flags through a read window that is gated by a 2-bit bank select.

On reaching Final, the block emits a single-cycle pulse and disarms itself. The comparators, the trace store and the actions taken on Final are outside this block.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the sequencer is disarmed. `seq_state` reads 2'b00 (State1), all flags are zero, and `final_pulse` is low. State encoding: 2'b00 State1, 2'b01 State2, 2'b10 State3, 2'b11 Final.
- R2: An `arm_req` pulse does three things on the next clock edge: it clears every flag, it places the sequencer in State1, and it sets `armed`. Matches presented in the same cycle as `arm_req` are ignored.
- R3: While armed, any match in State1 moves the sequencer to State2, and any match in State2 moves it to State3.
- R4: In State3, the following single-route codes apply; all other channels are ignored:
  - 4'b0010 sends a match on any channel to Final.
  - 4'b0011 sends channel 0 to State1; 4'b0100 sends channel 0 to State2.
  - 4'b0110 sends channel 1 to State1; 4'b0111 sends channel 1 to State2; 4'b1000 sends channel 1 to Final.
  - 4'b1100 sends channel 2 to Final; 4'b1101 sends channel 3 to Final.
- R5: In State3, the following two-route codes apply:
  - 4'b0101: channel 0 to Final, channel 1 to State1.
  - 4'b1001: channel 0 to Final, channel 2 to State2.
  - 4'b1010: channel 1 to State1, channel 3 to State2.
  - 4'b1011: channel 1 to Final, channel 3 to State2.
- R6: In State3, codes 4'b1110, 4'b1111, 4'b0000 and 4'b0001 route no channel, so the state does not change.
- R7: When several routed channels match in one cycle, a Final route wins over every other route. Among routes that do not lead to Final, the lowest-numbered channel wins.
- R8: While armed, a match on channel n sets flag n, and the flag stays set. A flag that is already set neither blocks other flags nor changes on a repeated match.
- R9: On the transition to Final, the following happen on that edge and hold as described:
  - `final_pulse` is high for exactly one cycle.
  - `armed` drops.
  - The flags keep their values.
  - Until the next arm strobe, matches change neither the state nor the flags.
- R10: When `bank_sel` is 2'b11, `flag_rd` returns the flags in bits 3:0 (bit n holds channel n) with bits 7:4 zero. For any other `bank_sel` value, `flag_rd` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_req | input | 1 | Arm strobe; starts a new session |
| match_i | input | 4 | Per-channel comparator match pulses |
| route_code | input | 4 | Next-state route code used in State3 |
| bank_sel | input | 2 | Register window bank select |
| seq_state | output | 2 | Current sequencer state |
| armed | output | 1 | Session active |
| final_pulse | output | 1 | One-cycle pulse on entering Final |
| flag_rd | output | 8 | Gated read of the match flags |

## Verification
Two things can happen in one cycle: flag capture and the state transition driven by the same match vector. The Final transition and the capture of the match that caused it also coincide. The bench drives every route code with all fifteen non-empty match patterns from State3, including multi-channel patterns that put a Final route against an earlier-channel route. It then checks the resolved state, the accumulated flags and the pulse on the same edge. Arm strobes are also driven together with matches, to confirm that arming wins and that those matches leave no flag behind.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    ST_ONE   = 2'b00,
    ST_TWO   = 2'b01,
    ST_THREE = 2'b10,
    ST_FIN   = 2'b11
  } seq_state_e;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_ONE  = 2'b01,
    RT_TWO  = 2'b10,
    RT_FIN  = 2'b11
  } route_e;

  // Route a single channel under a State3 code.
  function automatic route_e route_of(input logic [3:0] code, input int unsigned ch);
    route_e r;
    r = RT_NONE;
    unique case (code)
      4'b0010: r = (ch < 4) ? RT_FIN : RT_NONE;
      4'b0011: if (ch == 0) r = RT_ONE;
      4'b0100: if (ch == 0) r = RT_TWO;
      4'b0101: begin
        if (ch == 0) r = RT_FIN;
        if (ch == 1) r = RT_ONE;
      end
      4'b0110: if (ch == 1) r = RT_ONE;
      4'b0111: if (ch == 1) r = RT_TWO;
      4'b1000: if (ch == 1) r = RT_FIN;
      4'b1001: begin
        if (ch == 0) r = RT_FIN;
        if (ch == 2) r = RT_TWO;
      end
      4'b1010: begin
        if (ch == 1) r = RT_ONE;
        if (ch == 3) r = RT_TWO;
      end
      4'b1011: begin
        if (ch == 1) r = RT_FIN;
        if (ch == 3) r = RT_TWO;
      end
      4'b1100: if (ch == 2) r = RT_FIN;
      4'b1101: if (ch == 3) r = RT_FIN;
      default: r = RT_NONE;
    endcase
    return r;
  endfunction

  function automatic seq_state_e route_to_state(input route_e r);
    seq_state_e s;
    unique case (r)
      RT_ONE:  s = ST_ONE;
      RT_TWO:  s = ST_TWO;
      RT_FIN:  s = ST_FIN;
      default: s = ST_THREE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dbg_route_dec.sv
module dbg_route_dec
  import dbg_trig_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic [N_CH-1:0]   match,
  output logic              hit,
  output seq_state_e        target
);

  route_e          rt [N_CH];
  logic [N_CH-1:0] fin_vec;
  logic [N_CH-1:0] any_vec;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign rt[g]      = route_of(4'(code), g);
    assign fin_vec[g] = match[g] && (rt[g] == RT_FIN);
    assign any_vec[g] = match[g] && (rt[g] != RT_NONE);
  end

  // Final-bound routes first, then the lowest routed channel.
  always_comb begin
    hit    = |any_vec;
    target = ST_THREE;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (any_vec[i]) target = route_to_state(rt[i]);
    end
    if (|fin_vec) target = ST_FIN;
  end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_req,
  input  logic       match_any,
  input  logic       route_hit,
  input  seq_state_e route_tgt,
  output seq_state_e state,
  output logic       armed,
  output logic       final_pulse
);

  seq_state_e st_q, st_d;
  logic       arm_q, arm_d;
  logic       fin_q, fin_d;
  logic       run_en;

  assign run_en = arm_req || (arm_q && match_any);

  always_comb begin
    st_d  = st_q;
    arm_d = arm_q;
    fin_d = 1'b0;
    if (arm_req) begin
      st_d  = ST_ONE;
      arm_d = 1'b1;
    end else if (arm_q && match_any) begin
      unique case (st_q)
        ST_ONE: st_d = ST_TWO;
        ST_TWO: st_d = ST_THREE;
        ST_THREE: begin
          if (route_hit) begin
            st_d = route_tgt;
            if (route_tgt == ST_FIN) begin
              arm_d = 1'b0;
              fin_d = 1'b1;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ONE;
      arm_q <= 1'b0;
    end else if (run_en) begin
      st_q  <= st_d;
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= fin_d;
  end

  assign state       = st_q;
  assign armed       = arm_q;
  assign final_pulse = fin_q;

  p_arm_state1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> (st_q == ST_ONE) && arm_q);

  p_final_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);

  p_final_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (!arm_q && st_q == ST_FIN));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !arm_req) |=> $stable(st_q));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !arm_req && match_any && st_q == ST_ONE) |=> st_q == ST_TWO);

endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned RD_W   = 8,
  parameter logic [BANK_W-1:0] VIS_BANK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              armed,
  input  logic [N_CH-1:0]   match,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [RD_W-1:0]   rd_data
);

  localparam int unsigned PAD_W = RD_W - N_CH;

  logic [N_CH-1:0] flg_q, flg_d;
  logic            flg_en;

  assign flg_en = arm_req || (armed && (|match));

  always_comb begin
    if (arm_req) flg_d = '0;
    else         flg_d = flg_q | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (flg_en) flg_q <= flg_d;
  end

  always_comb begin
    rd_data = '0;
    if (bank_sel == VIS_BANK) rd_data = {{PAD_W{1'b0}}, flg_q};
  end

  p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> (flg_q == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_req |=> ((flg_q & $past(flg_q)) == $past(flg_q)));

  p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_req) |=> $stable(flg_q));

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned RD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic [N_CH-1:0]   match_i,
  input  logic [CODE_W-1:0] route_code,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [1:0]        seq_state,
  output logic              armed,
  output logic              final_pulse,
  output logic [RD_W-1:0]   flag_rd
);

  logic       rt_hit;
  seq_state_e rt_tgt;
  seq_state_e st;

  dbg_route_dec #(.N_CH(N_CH), .CODE_W(CODE_W)) u_dec (
    .code   (route_code),
    .match  (match_i),
    .hit    (rt_hit),
    .target (rt_tgt)
  );

  dbg_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_req     (arm_req),
    .match_any   (|match_i),
    .route_hit   (rt_hit),
    .route_tgt   (rt_tgt),
    .state       (st),
    .armed       (armed),
    .final_pulse (final_pulse)
  );

  dbg_flag_bank #(.N_CH(N_CH), .BANK_W(BANK_W), .RD_W(RD_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_req  (arm_req),
    .armed    (armed),
    .match    (match_i),
    .bank_sel (bank_sel),
    .rd_data  (flag_rd)
  );

  assign seq_state = st;

endmodule

// File: tb/dbg_trig_seq_tb.sv
`timescale 1ns/1ps
module dbg_trig_seq_tb;

  typedef struct {
    logic [1:0] st;
    logic       arm;
    logic [3:0] flg;
    logic       fin;
    logic [7:0] rd;
    int         st_req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_req = 1'b0;
  logic [3:0] match_i = '0;
  logic [3:0] route_code = '0;
  logic [1:0] bank_sel = '0;
  logic [1:0] seq_state;
  logic       armed, final_pulse;
  logic [7:0] flag_rd;

  int n_checks = 0;
  int n_fail = 0;
  exp_t q[$];

  logic [1:0] m_st;
  logic       m_arm;
  logic [3:0] m_flg;

  always #2.5 clk = ~clk;

  dbg_trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .match_i(match_i),
    .route_code(route_code), .bank_sel(bank_sel), .seq_state(seq_state),
    .armed(armed), .final_pulse(final_pulse), .flag_rd(flag_rd)
  );

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  // 0 none, 1 State1, 2 State2, 3 Final (expected from R4/R5/R6)
  function automatic int exp_route(input logic [3:0] c, input int ch);
    case (ch)
      0: case (c)
           4'b0010, 4'b0101, 4'b1001: return 3;
           4'b0011: return 1;
           4'b0100: return 2;
           default: return 0;
         endcase
      1: case (c)
           4'b0010, 4'b1000, 4'b1011: return 3;
           4'b0110, 4'b0101, 4'b1010: return 1;
           4'b0111: return 2;
           default: return 0;
         endcase
      2: case (c)
           4'b0010, 4'b1100: return 3;
           4'b1001: return 2;
           default: return 0;
         endcase
      default: case (c)
           4'b0010, 4'b1101: return 3;
           4'b1010, 4'b1011: return 2;
           default: return 0;
         endcase
    endcase
  endfunction

  function automatic int code_req(input logic [3:0] c, input logic [3:0] m);
    if ($countones(m) > 1) return 7;
    case (c)
      4'b0101, 4'b1001, 4'b1010, 4'b1011: return 5;
      4'b0000, 4'b0001, 4'b1110, 4'b1111: return 6;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string what, input int r, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_name(r), what, act, exp);
    end
  endtask

  // Drive one cycle of inputs and queue the expected post-edge outputs.
  task automatic step(input logic a, input logic [3:0] m, input logic [3:0] c,
                      input logic [1:0] b, input int st_r);
    exp_t e;
    logic fin;
    int best;
    @(negedge clk);
    arm_req = a; match_i = m; route_code = c; bank_sel = b;
    fin = 1'b0;
    if (a) begin
      m_st = 2'b00; m_arm = 1'b1; m_flg = 4'h0;
    end else if (m_arm && m != 0) begin
      m_flg = m_flg | m;
      if (m_st == 2'b00) m_st = 2'b01;
      else if (m_st == 2'b01) m_st = 2'b10;
      else begin
        best = 0;
        for (int ch = 0; ch < 4; ch++)
          if (m[ch] && exp_route(c, ch) == 3) best = 3;
        if (best == 0)
          for (int ch = 3; ch >= 0; ch--)
            if (m[ch] && exp_route(c, ch) != 0) best = exp_route(c, ch);
        if (best == 1) m_st = 2'b00;
        if (best == 2) m_st = 2'b01;
        if (best == 3) begin m_st = 2'b11; m_arm = 1'b0; fin = 1'b1; end
      end
    end
    e.st = m_st; e.arm = m_arm; e.flg = m_flg; e.fin = fin;
    e.rd = (b == 2'b11) ? {4'h0, m_flg} : 8'h00;
    e.st_req = st_r;
    q.push_back(e);
  endtask

  // Monitor: the edge after a step carries that step's results.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("state", e.st_req, seq_state, e.st);
      chk("armed", e.fin ? 9 : e.st_req, armed, e.arm);
      chk("flags", 8, flag_rd[3:0] & {4{bank_sel == 2'b11}}, e.flg & {4{bank_sel == 2'b11}});
      chk("final_pulse", 9, final_pulse, e.fin);
      chk("flag_rd", 10, flag_rd, e.rd);
    end
  end

  initial begin : wdog
    #(5ns * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_st = 2'b00; m_arm = 1'b0; m_flg = 4'h0;
    bank_sel = 2'b11;
    #12;
    // R1: reset state
    chk("reset state", 1, seq_state, 0);
    chk("reset armed", 1, armed, 0);
    chk("reset flags", 1, flag_rd, 0);
    chk("reset final", 1, final_pulse, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: disarmed matches ignored
    step(0, 4'hF, 4'b0010, 2'b11, 9);
    // R2: arm with coincident match, matches dropped
    step(1, 4'hF, 4'b0010, 2'b11, 2);
    // R3: advance, R8 flags accumulate
    step(0, 4'h1, 4'b1110, 2'b11, 3);
    step(0, 4'h4, 4'b1110, 2'b11, 3);
    // R6: reserved code, R8 repeated and new flags
    step(0, 4'hF, 4'b1110, 2'b11, 6);
    step(0, 4'h2, 4'b1111, 2'b11, 6);
    // R10: other banks read zero
    step(0, 4'h0, 4'b0000, 2'b00, 10);
    step(0, 4'h0, 4'b0000, 2'b10, 10);
    // R2: re-arm mid-session clears flags
    step(1, 4'h8, 4'b0000, 2'b11, 2);

    // R4 R5 R6 R7: every code against every non-empty match pattern
    for (int c = 0; c < 16; c++) begin
      for (int m = 1; m < 16; m++) begin
        step(1, 4'h0, 4'(c), 2'b11, 2);
        step(0, 4'(m) & 4'h3 | 4'h1, 4'(c), 2'(m), 3);
        step(0, 4'(m) & 4'h4, 4'(c), 2'b11, 3);
        if (m_st != 2'b10) step(0, 4'h1, 4'(c), 2'b11, 3);
        step(0, 4'(m), 4'(c), 2'(c), code_req(4'(c), 4'(m)));
        // R9: pulse drops, disarmed matches ignored, flags kept
        step(0, 4'hF, 4'(c), 2'b11, 9);
      end
    end

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule